// File: doc/BRIEF.md
# Equivalent-Time Sweep Capture Controller

This block records a repetitive analog waveform using nothing more than a one-bit comparator result and a DAC code it drives itself. Each sample is not converted in real time. Over many triggered repetitions of the signal, the block sweeps the reference downward one code at a time. On each repetition it tests every sample position against the current reference. When the sweep is finished, each memory slot holds the lowest reference code that was still above the input at that sample position.

A capture begins with a start pulse. The DAC code is set to full scale for the selected resolution and the block waits for an initial settling time. It then arms for a trigger edge of the selected polarity. After the edge it samples the comparator at a fixed interval, once for each slot of the record. After the pass it lowers the code by one, waits a step settling time and arms again. The pass taken at code zero is the last one. All timing values are given in clock cycles. Results are read through a combinational read port at any time.

Top module: `sweep_capture`

## Requirements
- R1: A start pulse seen while idle begins a capture. From the next cycle busy is high and dacCode holds full scale for cfgRes, where 0 selects 6 bits (63), 1 selects 7 bits (127), and 2 or 3 select 8 bits (255).
- R2: Accepting a start clears every memory slot to zero, so values left by an earlier capture do not survive.
- R3: Each pass begins only on a trigger edge of the selected polarity, with cfgFallEdge 0 meaning low-to-high and 1 meaning high-to-low. An edge of the other direction does not start a pass.
- R4: Let edge 0 be the first clock edge at which trigIn shows its active level. Sample k (counting from 0) uses the comparator level present at clock edge (k+1)*cfgInterval. A cfgInterval of 0 is treated as 1.
- R5: cmpIn high means the DAC level is above the input. At a sample where it is high, the current code is written to slot k. Otherwise slot k is unchanged. Either way the index advances, so a slot ends at the lowest code that was above its input, or at 0 if no code was.
- R6: After each pass except the last, dacCode drops by exactly one. Arming waits cfgInitSettle+1 cycles after start and cfgStepSettle+1 cycles after each step.
- R7: The capture ends after the pass at code zero. In that cycle done is high for exactly one cycle and busy is already low. Busy stays high through all 2^bits passes before that.
- R8: A start pulse while busy is ignored: neither the code nor the memory is reloaded.
- R9: rdData shows the slot selected by rdAddr without a clock delay. During a capture it returns the value written most recently.
- R10: cfgLength sets the number of slots per pass. A value of 0, or one above the depth, selects the full depth of 128. Slots past the record length keep the value zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a capture when idle |
| cfgRes | input | 2 | Resolution select: 0 gives 6 bits, 1 gives 7 bits, 2 or 3 give 8 bits |
| cfgFallEdge | input | 1 | Trigger polarity: 0 rising, 1 falling |
| cfgLength | input | 8 | Samples per pass (0 means full depth) |
| cfgInterval | input | 20 | Clock cycles between samples |
| cfgInitSettle | input | 20 | Settling cycles before the first pass |
| cfgStepSettle | input | 20 | Settling cycles after each code step |
| trigIn | input | 1 | Asynchronous trigger input |
| cmpIn | input | 1 | Asynchronous comparator, 1 when the DAC is above the input |
| dacCode | output | 8 | Reference code to the DAC |
| rdAddr | input | 7 | Sample memory read address |
| rdData | output | 8 | Sample memory read data |
| busy | output | 1 | Capture in progress |
| done | output | 1 | One-cycle pulse at the end of a capture |

## Verification
The end of a capture and the start of the next one can fall in the same cycle. The bench raises start in the very cycle done is high, so the new request meets the idle state while the completion pulse is still present. It then expects busy high, the new full-scale code, and a cleared memory on the following cycle. The last sample write and the code decrement share a cycle as well. The bench checks this by reading a slot back after every pass against a model that applies the write at the old code.

// File: rtl/sweep_capture_pkg.sv
`timescale 1ns/1ps
package sweep_capture_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_ARM,
    ST_SAMPLE
  } cap_state_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadCfg;
    logic clearMem;
    logic clrIdx;
    logic sampleNow;
    logic decCode;
  } cap_strobe_t;

  localparam logic [1:0] RES_SIX   = 2'd0;
  localparam logic [1:0] RES_SEVEN = 2'd1;

endpackage

// File: rtl/sweep_capture_ctrl.sv
`timescale 1ns/1ps
module sweep_capture_ctrl
  import sweep_capture_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] cfgInterval,
  input  logic [CNT_W-1:0] cfgInitSettle,
  input  logic [CNT_W-1:0] cfgStepSettle,
  input  logic             trigEdge,
  input  logic             codeZero,
  input  logic             lastIdx,
  output cap_strobe_t      strb,
  output logic             busy,
  output logic             done
);

  cap_state_e       state;
  logic [CNT_W-1:0] timer;
  logic [CNT_W-1:0] intervalQ;
  logic [CNT_W-1:0] stepQ;
  logic             timerZero;

  assign timerZero = (timer == '0);
  assign busy      = (state != ST_IDLE);

  always_comb begin
    strb = '0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strb.loadCfg  = 1'b1;
          strb.clearMem = 1'b1;
        end
      end
      ST_ARM: begin
        if (trigEdge) strb.clrIdx = 1'b1;
      end
      ST_SAMPLE: begin
        if (timerZero) begin
          strb.sampleNow = 1'b1;
          if (lastIdx && !codeZero) strb.decCode = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      timer     <= '0;
      intervalQ <= CNT_W'(1);
      stepQ     <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            intervalQ <= (cfgInterval == '0) ? CNT_W'(1) : cfgInterval;
            stepQ     <= cfgStepSettle;
            timer     <= cfgInitSettle;
            state     <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (timerZero) state <= ST_ARM;
          else           timer <= timer - 1'b1;
        end
        ST_ARM: begin
          if (trigEdge) begin
            timer <= intervalQ - 1'b1;
            state <= ST_SAMPLE;
          end
        end
        ST_SAMPLE: begin
          if (timerZero) begin
            if (lastIdx) begin
              if (codeZero) begin
                state <= ST_IDLE;
                done  <= 1'b1;
              end else begin
                timer <= stepQ;
                state <= ST_SETTLE;
              end
            end else begin
              timer <= intervalQ - 1'b1;
            end
          end else begin
            timer <= timer - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sweep_capture_dp.sv
`timescale 1ns/1ps
module sweep_capture_dp
  import sweep_capture_pkg::*;
#(
  parameter int DAC_W = 8,
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = IDX_W + 1,
  localparam int ADDR_SLOTS = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  cap_strobe_t      strb,
  input  logic [1:0]       cfgRes,
  input  logic             cfgFallEdge,
  input  logic [LEN_W-1:0] cfgLength,
  input  logic             trigIn,
  input  logic             cmpIn,
  input  logic [IDX_W-1:0] rdAddr,
  output logic [DAC_W-1:0] rdData,
  output logic [DAC_W-1:0] dacCode,
  output logic             trigEdge,
  output logic             codeZero,
  output logic             lastIdx
);

  logic             cmpS1, cmpS2;
  logic             trgS1, trgS2, trgPrev;
  logic             fallSel;
  logic [LEN_W-1:0] lenQ;
  logic [IDX_W-1:0] idx;
  logic [DAC_W-1:0] fullScale;
  logic             wrEn;
  logic [DAC_W-1:0] slotArr [ADDR_SLOTS];

  // two-flop synchronizers and edge detection on the synchronized trigger
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpS1   <= 1'b0;
      cmpS2   <= 1'b0;
      trgS1   <= 1'b0;
      trgS2   <= 1'b0;
      trgPrev <= 1'b0;
    end else begin
      cmpS1   <= cmpIn;
      cmpS2   <= cmpS1;
      trgS1   <= trigIn;
      trgS2   <= trgS1;
      trgPrev <= trgS2;
    end
  end

  assign trigEdge = fallSel ? (!trgS2 && trgPrev) : (trgS2 && !trgPrev);

  always_comb begin
    case (cfgRes)
      RES_SIX:   fullScale = {DAC_W{1'b1}} >> 2;
      RES_SEVEN: fullScale = {DAC_W{1'b1}} >> 1;
      default:   fullScale = {DAC_W{1'b1}};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fallSel <= 1'b0;
      lenQ    <= LEN_W'(DEPTH);
      dacCode <= '0;
      idx     <= '0;
    end else begin
      if (strb.loadCfg) begin
        fallSel <= cfgFallEdge;
        lenQ    <= (cfgLength == '0 || cfgLength > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : cfgLength;
        dacCode <= fullScale;
      end else if (strb.decCode) begin
        dacCode <= dacCode - 1'b1;
      end
      if (strb.clrIdx)         idx <= '0;
      else if (strb.sampleNow) idx <= idx + 1'b1;
    end
  end

  assign codeZero = (dacCode == '0);
  assign lastIdx  = ({1'b0, idx} == lenQ - 1'b1);
  assign wrEn     = strb.sampleNow && cmpS2;

  for (genvar s = 0; s < ADDR_SLOTS; s++) begin : g_slot
    if (s < DEPTH) begin : g_live
      logic [DAC_W-1:0] slotQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                               slotQ <= '0;
        else if (strb.clearMem)                  slotQ <= '0;
        else if (wrEn && idx == IDX_W'(s))       slotQ <= dacCode;
      end
      assign slotArr[s] = slotQ;
    end else begin : g_pad
      assign slotArr[s] = '0;
    end
  end

  assign rdData = slotArr[rdAddr];

endmodule

// File: rtl/sweep_capture.sv
`timescale 1ns/1ps
module sweep_capture
  import sweep_capture_pkg::*;
#(
  parameter int DAC_W = 8,
  parameter int DEPTH = 128,
  parameter int CNT_W = 20,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       cfgRes,
  input  logic             cfgFallEdge,
  input  logic [LEN_W-1:0] cfgLength,
  input  logic [CNT_W-1:0] cfgInterval,
  input  logic [CNT_W-1:0] cfgInitSettle,
  input  logic [CNT_W-1:0] cfgStepSettle,
  input  logic             trigIn,
  input  logic             cmpIn,
  output logic [DAC_W-1:0] dacCode,
  input  logic [IDX_W-1:0] rdAddr,
  output logic [DAC_W-1:0] rdData,
  output logic             busy,
  output logic             done
);

  cap_strobe_t strb;
  logic        trigEdge;
  logic        codeZero;
  logic        lastIdx;

  sweep_capture_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .start         (start),
    .cfgInterval   (cfgInterval),
    .cfgInitSettle (cfgInitSettle),
    .cfgStepSettle (cfgStepSettle),
    .trigEdge      (trigEdge),
    .codeZero      (codeZero),
    .lastIdx       (lastIdx),
    .strb          (strb),
    .busy          (busy),
    .done          (done)
  );

  sweep_capture_dp #(.DAC_W(DAC_W), .DEPTH(DEPTH)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cfgRes      (cfgRes),
    .cfgFallEdge (cfgFallEdge),
    .cfgLength   (cfgLength),
    .trigIn      (trigIn),
    .cmpIn       (cmpIn),
    .rdAddr      (rdAddr),
    .rdData      (rdData),
    .dacCode     (dacCode),
    .trigEdge    (trigEdge),
    .codeZero    (codeZero),
    .lastIdx     (lastIdx)
  );

endmodule

// File: rtl/sweep_capture_chk.sv
`timescale 1ns/1ps
module sweep_capture_chk #(
  parameter int DAC_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [1:0]       cfgRes,
  input logic             busy,
  input logic             done,
  input logic [DAC_W-1:0] dacCode
);

  function automatic logic [DAC_W-1:0] topCode(input logic [1:0] r);
    if (r == 2'd0)      return DAC_W'((1 << (DAC_W - 2)) - 1);
    else if (r == 2'd1) return DAC_W'((1 << (DAC_W - 1)) - 1);
    else                return {DAC_W{1'b1}};
  endfunction

  // R1: an accepted start loads full scale and raises busy
  a_r1_full_scale: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && dacCode == topCode($past(cfgRes))));

  // R6: while running the code only ever moves down by one
  a_r6_step_one: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && dacCode != $past(dacCode))
      |-> (dacCode == DAC_W'($past(dacCode) - 1'b1)));

  // R7: done ends a capture at code zero, with busy already low
  a_r7_done_end: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy) && dacCode == '0));

  // R7: done lasts a single cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: start during a capture never reloads the code
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (dacCode <= $past(dacCode)));

endmodule

bind sweep_capture sweep_capture_chk #(.DAC_W(DAC_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .cfgRes  (cfgRes),
  .busy    (busy),
  .done    (done),
  .dacCode (dacCode)
);

// File: tb/sweep_capture_bench.sv
`timescale 1ns/1ps
module sweep_capture_bench;

  localparam int DEPTH = 128;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  cfgRes = 2'd2;
  logic        cfgFallEdge = 1'b0;
  logic [7:0]  cfgLength = 8'd0;
  logic [19:0] cfgInterval = 20'd1;
  logic [19:0] cfgInitSettle = 20'd0;
  logic [19:0] cfgStepSettle = 20'd0;
  logic        trigIn = 1'b0;
  logic        cmpIn = 1'b0;
  logic [7:0]  dacCode;
  logic [6:0]  rdAddr = 7'd0;
  logic [7:0]  rdData;
  logic        busy;
  logic        done;

  int checks = 0;
  int failures = 0;
  int wave [DEPTH];
  int model [DEPTH];

  always #2 clk = ~clk;

  sweep_capture u_sweep_capture (
    .clk(clk), .rstN(rstN), .start(start), .cfgRes(cfgRes), .cfgFallEdge(cfgFallEdge),
    .cfgLength(cfgLength), .cfgInterval(cfgInterval), .cfgInitSettle(cfgInitSettle),
    .cfgStepSettle(cfgStepSettle), .trigIn(trigIn), .cmpIn(cmpIn), .dacCode(dacCode),
    .rdAddr(rdAddr), .rdData(rdData), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int slotExpect(input int w, input int maxc);
    return (w < maxc) ? w + 1 : 0;
  endfunction

  task automatic setCfg(input int res, input bit fall, input int intv, input int len,
                        input int stepS, input int initS);
    cfgRes = 2'(res); cfgFallEdge = fall; cfgInterval = 20'(intv);
    cfgLength = 8'(len); cfgStepSettle = 20'(stepS); cfgInitSettle = 20'(initS);
  endtask

  task automatic pulseStart();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic genWave(input int maxc);
    for (int k = 0; k < DEPTH; k++) wave[k] = int'($urandom % (maxc + 4));
    wave[0] = 0; wave[1] = maxc - 1; wave[2] = maxc; wave[3] = maxc + 5;
  endtask

  task automatic afterStart(input int maxc, input int initS);
    @(negedge clk);
    chk(busy == 1'b1, "R1 busy after start", busy, 1);
    chk(dacCode == 8'(maxc), "R1 full scale code", dacCode, maxc);
    chk(done == 1'b0, "R7 no done at start", done, 0);
    for (int a = 0; a < DEPTH; a++) begin
      rdAddr = 7'(a); #0.1;
      chk(rdData == 8'd0, "R2 slot cleared", rdData, 0);
      model[a] = 0;
    end
    repeat (initS + 10) @(posedge clk);
    #1;
  endtask

  task automatic runPass(input int intv, input int len, input int stepS, input bit fall,
                         input int code, input bit last, input bit chain, input int slot);
    @(negedge clk);
    chk(dacCode == 8'(code), "R6 code before pass", dacCode, code);
    chk(busy == 1'b1, "R7 busy during sweep", busy, 1);
    @(posedge clk); #1 trigIn = fall ? 1'b0 : 1'b1;
    for (int c = 1; c <= len * intv; c++) begin
      @(posedge clk); #1 cmpIn = (code > wave[(c - 1) / intv]);
    end
    for (int k = 0; k < len; k++) if (code > wave[k]) model[k] = code;
    @(posedge clk); #1 trigIn = fall ? 1'b1 : 1'b0; cmpIn = 1'b0;
    if (!last) begin
      repeat (stepS + 8) @(posedge clk);
      #1 rdAddr = 7'(slot);
      @(negedge clk);
      chk(rdData == 8'(model[slot]), "R9 mid-capture readback", rdData, model[slot]);
    end else begin
      bit seen = 1'b0;
      for (int n = 0; n < 24 && !seen; n++) begin
        @(negedge clk);
        if (done) begin
          seen = 1'b1;
          chk(busy == 1'b0, "R7 busy low with done", busy, 0);
          if (chain) start = 1'b1;
        end
      end
      chk(seen, "R7 done after code zero pass", seen, 1);
      if (chain) begin
        @(posedge clk); #1 start = 1'b0;
      end else begin
        @(negedge clk);
        chk(done == 1'b0, "R7 done single cycle", done, 0);
      end
    end
  endtask

  task automatic finalCheck(input int maxc, input int len);
    for (int a = 0; a < DEPTH; a++) begin
      int exp;
      exp = (a < len) ? slotExpect(wave[a], maxc) : 0;
      rdAddr = 7'(a); #0.1;
      chk(rdData == 8'(exp), "R4 R5 R10 final slot", rdData, exp);
      chk(exp == model[a], "R5 model agreement", model[a], exp);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd24681));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R7 reset busy", busy, 0);
    chk(done == 1'b0, "R7 reset done", done, 0);
    chk(dacCode == 8'd0, "R1 reset code", dacCode, 0);
    chk(rdData == 8'd0, "R2 reset slot", rdData, 0);
    #1 rstN = 1'b1;

    // capture 1: 8-bit, rising, interval 4, 12 slots
    setCfg(2, 1'b0, 4, 12, 3, 5);
    trigIn = 1'b0;
    pulseStart();
    afterStart(255, 5);
    genWave(255);
    for (int code = 255; code >= 0; code--)
      runPass(4, 12, 3, 1'b0, code, code == 0, 1'b0, code % 12);
    finalCheck(255, 12);

    // capture 2: 6-bit, falling, interval 1, full depth via length 0
    setCfg(0, 1'b1, 1, 0, 3, 6);
    trigIn = 1'b0;
    pulseStart();
    afterStart(63, 6);
    genWave(63);
    @(posedge clk); #1 trigIn = 1'b1;   // wrong direction for this capture
    repeat (DEPTH + 3 + 10) @(posedge clk);
    @(negedge clk);
    chk(dacCode == 8'd63, "R3 opposite edge ignored", dacCode, 63);
    for (int code = 63; code >= 0; code--) begin
      if (code == 60) begin
        cfgRes = 2'd2;
        pulseStart();
        @(negedge clk);
        chk(dacCode == 8'd60, "R8 start while busy ignored", dacCode, 60);
        chk(busy == 1'b1, "R8 still busy", busy, 1);
      end
      if (code == 0) begin
        finalCheck(63, DEPTH);
        setCfg(1, 1'b0, 7, 20, 2, 4);
      end
      runPass(1, DEPTH, 3, 1'b1, code, code == 0, 1'b1, code % DEPTH);
    end

    // capture 3: started in the done cycle; 7-bit, rising, interval 7, 20 slots
    afterStart(127, 4);
    trigIn = 1'b0;
    genWave(127);
    repeat (4) @(posedge clk);
    #1;
    for (int code = 127; code >= 0; code--)
      runPass(7, 20, 2, 1'b0, code, code == 0, 1'b0, code % 20);
    finalCheck(127, 20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule